// File: doc/BRIEF.md
# Strap-Sampled Address and Status Indicator Pins

This block runs a small group of dual-role pins on a 10/100 Ethernet transceiver. While the power-on or hardware reset input is low, every pin is kept as a high-impedance input. The block passes each pin level through a two-flop synchronizer. When reset is released, it latches those levels once. The latched word becomes the device's management address, and each bit also records which way its pin is biased. From then on, every pin is driven as an output. It shows one status event chosen by a per-pin selector.

The level a pin drives depends on the bias latched for it. When the indication is off, the pin drives the latched level. When it is on, the pin drives the inverse of that level, so the LED wired to the pin lights. Short events (activity, transmit and receive) are stretched so that each one stays visible for 2^STRETCH_W clocks. A software reset leaves the latched address and the pin directions alone. It holds every indicator off and clears the stretch state. An all-zero latched address raises the tri-state enable of the reduced MII data path.

Event inputs are single-bit, clock-synchronous levels. The selector inputs and the software reset are plain control pins. No stream interface exists, so there is no back-pressure.

Top module: `strap_led_ctrl`

## Requirements
- R1: While `hw_rst_n` is low, `pin_oe`, `pin_out`, `phy_addr`, `strap_valid` and `rmii_tristate` are all zero.
- R2: Pin levels go through two synchronizer flops. The latch happens on the third rising clock edge after `hw_rst_n` goes high. From that edge on, `strap_valid` is 1 and every `pin_oe` bit is 1.
- R3: Bit i of `phy_addr` is the synchronized level of `pin_in[i]` at the latch edge. Later changes on `pin_in` have no effect on it until the next hardware reset.
- R4: `sw_rst` does not change `phy_addr`, `strap_valid` or `pin_oe`.
- R5: While `sw_rst` is high, every `pin_out[i]` equals `phy_addr[i]`. Stretch counters are cleared, so a stretched indication that was running is off once `sw_rst` falls.
- R6: `rmii_tristate` is 1 exactly when `strap_valid` is 1 and `phy_addr` is all zero.
- R7: After the latch, `pin_out[i]` is `phy_addr[i]` when its indication is off and `~phy_addr[i]` when it is on. An event level sampled at a rising edge shows on the pin right after that edge.
- R8: The selector for pin i is `led_sel[3*i+2:3*i]`. The codes are 0 link, 1 activity, 2 transmit, 3 receive, 4 speed (1 = 100 Mb/s), 5 duplex (1 = full). Codes 6 and 7 hold the indication off.
- R9: Activity, transmit and receive are stretched. If the event is high at edge k, the indication is on after edges k through k+2^STRETCH_W-1. A new high sample reloads the full window.
- R10: Link, speed and duplex are not stretched. Their indication follows the level sampled at the last edge.
- R11: A new hardware reset makes the pins inputs again, and the following release latches the current pin levels afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Power-on / hardware reset, active low, asynchronous assert |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| pin_in | input | NPINS | Level seen at each dual-role pad |
| pin_out | output | NPINS | Level driven to each pad when enabled |
| pin_oe | output | NPINS | Pad output enable, 0 = high impedance |
| ev_link | input | 1 | Link-up status level |
| ev_act | input | 1 | Activity event |
| ev_tx | input | 1 | Transmit event |
| ev_rx | input | 1 | Receive event |
| ev_speed | input | 1 | Speed status, 1 = 100 Mb/s |
| ev_duplex | input | 1 | Duplex status, 1 = full |
| led_sel | input | 3*NPINS | Event selector per pin, 3 bits each |
| phy_addr | output | NPINS | Latched address |
| strap_valid | output | 1 | Latch has happened since the last hardware reset |
| rmii_tristate | output | 1 | Tri-state enable for the reduced MII data path |

## Verification
The bench builds the block with NPINS = 3 and STRETCH_W = 3. Three pins are enough to mix pins biased high and low, to put one pin on a stretched event, one on a level event and one on an off code at the same time, and to reach the all-zero address. An eight-clock stretch window lets the bench measure the exact pulse length, retrigger the window in the middle and cut it with a software reset within a few dozen cycles.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int NUM_EV = 6;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_LINK   = 3'd0,
    EV_ACT    = 3'd1,
    EV_TX     = 3'd2,
    EV_RX     = 3'd3,
    EV_SPEED  = 3'd4,
    EV_DUPLEX = 3'd5,
    EV_OFF_A  = 3'd6,
    EV_OFF_B  = 3'd7
  } ev_sel_e;

  // short events that need a minimum visible width
  function automatic bit is_stretched(int idx);
    return (idx == int'(EV_ACT)) || (idx == int'(EV_TX)) || (idx == int'(EV_RX));
  endfunction

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      stage2 <= stage1;
    end
  end

  assign rst_sync_n = stage2;
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         rst_sync_n,
  input  logic [W-1:0] pad_lvl,
  output logic [W-1:0] cap_word,
  output logic         cap_done
);
  // synchronizer runs through reset so its output is settled at release
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    meta_q <= pad_lvl;
    sync_q <= meta_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cap_word <= '0;
      cap_done <= 1'b0;
    end else if (rst_sync_n && !cap_done) begin
      cap_word <= sync_q;
      cap_done <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_event_cond.sv
module strap_event_cond
  import strap_pkg::*;
#(
  parameter int STRETCH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic [NUM_EV-1:0] ev_raw,
  output logic [NUM_EV-1:0] ev_q
);
  localparam logic [STRETCH_W-1:0] HOLD_LAST = '1;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    logic lvl;
    if (is_stretched(g)) begin : g_str
      logic [STRETCH_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
          lvl <= 1'b0;
        end else if (sw_rst) begin
          cnt <= '0;
          lvl <= 1'b0;
        end else if (ev_raw[g]) begin
          cnt <= HOLD_LAST;
          lvl <= 1'b1;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
          lvl <= 1'b1;
        end else begin
          lvl <= 1'b0;
        end
      end
    end else begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl <= 1'b0;
        end else if (sw_rst) begin
          lvl <= 1'b0;
        end else begin
          lvl <= ev_raw[g];
        end
      end
    end
    assign ev_q[g] = lvl;
  end
endmodule

// File: rtl/strap_led_drive.sv
module strap_led_drive
  import strap_pkg::*;
(
  input  logic              cap_lvl,
  input  logic              cap_done,
  input  logic              sw_rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_EV-1:0] ev_q,
  output logic              pad_out,
  output logic              pad_oe
);
  logic active;

  always_comb begin
    case (ev_sel_e'(sel))
      EV_LINK:   active = ev_q[int'(EV_LINK)];
      EV_ACT:    active = ev_q[int'(EV_ACT)];
      EV_TX:     active = ev_q[int'(EV_TX)];
      EV_RX:     active = ev_q[int'(EV_RX)];
      EV_SPEED:  active = ev_q[int'(EV_SPEED)];
      EV_DUPLEX: active = ev_q[int'(EV_DUPLEX)];
      default:   active = 1'b0;
    endcase
  end

  // the lit level is the opposite of the bias latched at reset release
  assign pad_out = cap_done ? (cap_lvl ^ (active & ~sw_rst)) : 1'b0;
  assign pad_oe  = cap_done;
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_pkg::*;
#(
  parameter int NPINS     = 5,
  parameter int STRETCH_W = 4
) (
  input  logic                   clk,
  input  logic                   hw_rst_n,
  input  logic                   sw_rst,
  input  logic [NPINS-1:0]       pin_in,
  output logic [NPINS-1:0]       pin_out,
  output logic [NPINS-1:0]       pin_oe,
  input  logic                   ev_link,
  input  logic                   ev_act,
  input  logic                   ev_tx,
  input  logic                   ev_rx,
  input  logic                   ev_speed,
  input  logic                   ev_duplex,
  input  logic [SEL_W*NPINS-1:0] led_sel,
  output logic [NPINS-1:0]       phy_addr,
  output logic                   strap_valid,
  output logic                   rmii_tristate
);
  logic              rst_sync_n;
  logic [NUM_EV-1:0] ev_raw;
  logic [NUM_EV-1:0] ev_q;

  always_comb begin
    ev_raw = '0;
    ev_raw[int'(EV_LINK)]   = ev_link;
    ev_raw[int'(EV_ACT)]    = ev_act;
    ev_raw[int'(EV_TX)]     = ev_tx;
    ev_raw[int'(EV_RX)]     = ev_rx;
    ev_raw[int'(EV_SPEED)]  = ev_speed;
    ev_raw[int'(EV_DUPLEX)] = ev_duplex;
  end

  strap_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (hw_rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strap_capture #(.W(NPINS)) u_capture (
    .clk        (clk),
    .arst_n     (hw_rst_n),
    .rst_sync_n (rst_sync_n),
    .pad_lvl    (pin_in),
    .cap_word   (phy_addr),
    .cap_done   (strap_valid)
  );

  strap_event_cond #(.STRETCH_W(STRETCH_W)) u_events (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sw_rst (sw_rst),
    .ev_raw (ev_raw),
    .ev_q   (ev_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    strap_led_drive u_drive (
      .cap_lvl  (phy_addr[p]),
      .cap_done (strap_valid),
      .sw_rst   (sw_rst),
      .sel      (led_sel[SEL_W*p +: SEL_W]),
      .ev_q     (ev_q),
      .pad_out  (pin_out[p]),
      .pad_oe   (pin_oe[p])
    );
  end

  assign rmii_tristate = strap_valid && (phy_addr == '0);
endmodule

// File: rtl/strap_led_chk.sv
module strap_led_chk #(
  parameter int NPINS = 5
) (
  input logic               clk,
  input logic               hw_rst_n,
  input logic               sw_rst,
  input logic [3*NPINS-1:0] led_sel,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_oe,
  input logic [NPINS-1:0]   phy_addr,
  input logic               strap_valid,
  input logic               rmii_tristate
);
  AST_QUIET_BEFORE_LATCH: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !strap_valid |-> (pin_oe == '0) && (pin_out == '0) && !rmii_tristate); // R1

  AST_DRIVE_ON_LATCH: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $rose(strap_valid) |-> (pin_oe == '1) && ($past(pin_oe) == '0)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!hw_rst_n)
    strap_valid |=> strap_valid && $stable(phy_addr)); // R3

  AST_SOFT_KEEPS_DIR: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && strap_valid) |=> strap_valid && (pin_oe == '1)); // R4

  AST_SOFT_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && strap_valid) |-> (pin_out == phy_addr)); // R5

  AST_ZERO_ADDR_ISOLATE: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (strap_valid && (phy_addr == '0)) |-> rmii_tristate); // R6

  AST_LIVE_ADDR_CONNECT: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (phy_addr != '0) |-> !rmii_tristate); // R6

  for (genvar p = 0; p < NPINS; p++) begin : g_off
    AST_OFF_CODE_IDLE: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (strap_valid && (led_sel[3*p +: 3] >= 3'd6)) |-> (pin_out[p] == phy_addr[p])); // R8
  end
endmodule

bind strap_led_ctrl strap_led_chk #(.NPINS(NPINS)) u_strap_led_chk (
  .clk           (clk),
  .hw_rst_n      (hw_rst_n),
  .sw_rst        (sw_rst),
  .led_sel       (led_sel),
  .pin_out       (pin_out),
  .pin_oe        (pin_oe),
  .phy_addr      (phy_addr),
  .strap_valid   (strap_valid),
  .rmii_tristate (rmii_tristate)
);

// File: tb/test_strap_led_ctrl.sv
module test_strap_led_ctrl;
  localparam int NP  = 3;
  localparam int SW  = 3;
  localparam int LEN = 1 << SW;

  logic          clk = 1'b0;
  logic          hw_rst_n;
  logic          sw_rst;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          ev_link, ev_act, ev_tx, ev_rx, ev_speed, ev_duplex;
  logic [3*NP-1:0] led_sel;
  logic [NP-1:0] phy_addr;
  logic          strap_valid;
  logic          rmii_tristate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strap_led_ctrl #(.NPINS(NP), .STRETCH_W(SW)) i_strap_led_ctrl (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ev_link(ev_link), .ev_act(ev_act),
    .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_speed(ev_speed), .ev_duplex(ev_duplex),
    .led_sel(led_sel), .phy_addr(phy_addr), .strap_valid(strap_valid),
    .rmii_tristate(rmii_tristate)
  );

  // behavioural reference state
  bit            m_r1 = 0, m_r2 = 0, m_valid = 0;
  logic [NP-1:0] m_addr = '0;
  logic [NP-1:0] m_s1, m_s2;
  bit            m_lvl [6];
  int            m_cnt [6];

  initial for (int c = 0; c < 6; c++) begin m_lvl[c] = 0; m_cnt[c] = 0; end

  function automatic bit raw_ev(int c);
    case (c)
      0: return ev_link;
      1: return ev_act;
      2: return ev_tx;
      3: return ev_rx;
      4: return ev_speed;
      default: return ev_duplex;
    endcase
  endfunction

  always @(posedge clk) begin
    if (hw_rst_n !== 1'b1) begin
      m_r1 = 0; m_r2 = 0; m_valid = 0; m_addr = '0;
      for (int c = 0; c < 6; c++) begin m_lvl[c] = 0; m_cnt[c] = 0; end
    end else begin
      for (int c = 0; c < 6; c++) begin
        if (!m_r2 || sw_rst) begin
          m_lvl[c] = 0; m_cnt[c] = 0;
        end else if (c >= 1 && c <= 3) begin
          if (raw_ev(c)) begin m_cnt[c] = LEN - 1; m_lvl[c] = 1; end
          else if (m_cnt[c] > 0) begin m_cnt[c]--; m_lvl[c] = 1; end
          else m_lvl[c] = 0;
        end else begin
          m_lvl[c] = raw_ev(c);
        end
      end
      if (m_r2 && !m_valid) begin m_valid = 1; m_addr = m_s2; end
      m_r2 = m_r1;
      m_r1 = 1;
    end
    m_s2 = m_s1;
    m_s1 = pin_in;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_pin(int i);
    int  s;
    bit  a;
    if (!m_valid) return 1'b0;
    s = int'(led_sel[3*i +: 3]);
    a = (s < 6) ? m_lvl[s] : 1'b0;
    if (sw_rst) a = 1'b0;
    return m_addr[i] ^ a;
  endfunction

  task automatic compare_all();
    logic [NP-1:0] eo;
    string tag;
    int s;
    for (int i = 0; i < NP; i++) eo[i] = exp_pin(i);
    chk(pin_oe === (m_valid ? {NP{1'b1}} : {NP{1'b0}}), m_valid ? "R2" : "R1",
        int'(pin_oe), m_valid ? (1 << NP) - 1 : 0);
    chk(strap_valid === m_valid, m_valid ? "R2" : "R1", int'(strap_valid), int'(m_valid));
    chk(phy_addr === m_addr, m_valid ? "R3" : "R1", int'(phy_addr), int'(m_addr));
    chk(rmii_tristate === (m_valid && m_addr == '0), "R6", int'(rmii_tristate),
        int'(m_valid && m_addr == '0));
    for (int i = 0; i < NP; i++) begin
      s = int'(led_sel[3*i +: 3]);
      if (!m_valid) tag = "R1";
      else if (sw_rst) tag = "R5";
      else if (s >= 6) tag = "R8";
      else if (s >= 1 && s <= 3) tag = "R9";
      else tag = "R10";
      chk(pin_out[i] === eo[i], tag, int'(pin_out[i]), int'(eo[i]));
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic set_sel(int p, int code);
    led_sel[3*p +: 3] = 3'(code);
  endtask

  initial begin
    int k;
    hw_rst_n = 0; sw_rst = 0; pin_in = 3'b101;
    {ev_link, ev_act, ev_tx, ev_rx, ev_speed, ev_duplex} = '0;
    led_sel = '0;
    set_sel(0, 0); set_sel(1, 1); set_sel(2, 6);
    step(5);
    // R1: reset state
    chk(pin_oe == '0 && !strap_valid, "R1", int'(pin_oe), 0);
    hw_rst_n = 1;
    k = 0;
    do begin step(); k++; end while (!strap_valid && k < 10);
    chk(k == 3, "R2", k, 3);
    chk(phy_addr == 3'b101, "R3", int'(phy_addr), 5);
    chk(!rmii_tristate, "R6", int'(rmii_tristate), 0);
    pin_in = 3'b010;
    step(4);
    chk(phy_addr == 3'b101, "R3", int'(phy_addr), 5);
    // link on pin0 (latched 1): lit level is 0
    ev_link = 1; step();
    chk(pin_out[0] == 1'b0, "R7", int'(pin_out[0]), 0);
    ev_link = 0; step();
    chk(pin_out[0] == 1'b1, "R10", int'(pin_out[0]), 1);
    // activity on pin1 (latched 0): one-cycle pulse stretched
    ev_act = 1; step(); ev_act = 0;
    k = 0;
    while (pin_out[1] == 1'b1 && k < 40) begin k++; step(); end
    chk(k == LEN, "R9", k, LEN);
    // retrigger in the middle of the window
    ev_act = 1; step(); ev_act = 0; step(4);
    ev_act = 1; step(); ev_act = 0;
    k = 0;
    while (pin_out[1] == 1'b1 && k < 40) begin k++; step(); end
    chk(k == LEN, "R9", k, LEN);
    // off codes ignore every event
    {ev_link, ev_act, ev_tx, ev_rx, ev_speed, ev_duplex} = '1;
    set_sel(2, 6); step(2);
    chk(pin_out[2] == 1'b1, "R8", int'(pin_out[2]), 1);
    set_sel(2, 7); step(2);
    chk(pin_out[2] == 1'b1, "R8", int'(pin_out[2]), 1);
    {ev_link, ev_act, ev_tx, ev_rx, ev_speed, ev_duplex} = '0;
    set_sel(0, 4); set_sel(1, 2); set_sel(2, 5);
    ev_speed = 1; ev_tx = 1; ev_duplex = 1; step(); ev_tx = 0; step(3);
    set_sel(1, 3); ev_rx = 1; step(); ev_rx = 0; step(LEN + 2);
    ev_speed = 0; ev_duplex = 0; step(2);
    // software reset in the middle of a stretch window
    set_sel(1, 1); ev_act = 1; step(); ev_act = 0; step(2);
    sw_rst = 1; ev_link = 1; step(3);
    chk(pin_out == phy_addr, "R5", int'(pin_out), int'(phy_addr));
    chk(strap_valid && pin_oe == '1 && phy_addr == 3'b101, "R4", int'(phy_addr), 5);
    sw_rst = 0; ev_link = 0; step();
    chk(pin_out[1] == 1'b0, "R5", int'(pin_out[1]), 0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      {ev_link, ev_act, ev_tx, ev_rx, ev_speed, ev_duplex} = 6'($urandom);
      if (($urandom % 4) != 0) {ev_act, ev_tx, ev_rx} = '0;
      if (($urandom % 16) == 0) led_sel = 9'($urandom);
      sw_rst = (($urandom % 40) == 0);
      step();
    end
    sw_rst = 0;
    // new hardware reset latches all-zero address
    hw_rst_n = 0; pin_in = 3'b000; step();
    chk(pin_oe == '0 && !strap_valid, "R11", int'(pin_oe), 0);
    step(3); hw_rst_n = 1; step(4);
    chk(strap_valid && phy_addr == 3'b000, "R11", int'(phy_addr), 0);
    chk(rmii_tristate, "R6", int'(rmii_tristate), 1);
    for (int n = 0; n < 100; n++) begin
      {ev_link, ev_act, ev_tx, ev_rx, ev_speed, ev_duplex} = 6'($urandom);
      if (($urandom % 8) == 0) led_sel = 9'($urandom);
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule